// File: doc/BRIEF.md
# Multiplexed Channel Scan Sequencer

This block runs a scan over a bank of held charge-integrator channels that all share one external converter. When the host pulses the scan trigger, the block walks the channels one at a time. It sets the analog multiplexer select and holds it through a settling interval. It then issues a one-cycle start to the converter and waits for the converter's end-of-conversion strobe. At that point it files the result under the channel's index. When the final channel has been written, it raises a one-cycle scan-complete pulse.

The multiplexer, the amplifiers and the converter all sit outside the block. The settling time is a clock-cycle count parameter. The conversion time is whatever the converter takes. Each channel therefore costs the settling cycles, plus one start cycle, plus the cycles spent waiting for the strobe, and the whole scan costs that amount times the channel count. With the default 48 channels and 12-bit results, a board carries two such groups. The host can read any stored result by channel number through a read port that has one cycle of latency.

Top module: `chan_scan_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, scan_busy, scan_done and conv_start are 0 and mux_sel is 0. Every stored result reads back as 0 until a scan writes it.
- R2: A scan_trig sampled high while idle raises scan_busy from the next cycle, with mux_sel equal to 0.
- R3: Channels are visited in ascending order from 0 to NUM_CH-1, and each channel gets exactly one conv_start per scan. mux_sel changes only on the first cycle of a settling interval and never while idle.
- R4: conv_start is a single-cycle pulse. It is asserted in the cycle that follows exactly SETTLE_CYC cycles with the current mux_sel held.
- R5: The conv_data present in the cycle where conv_eoc is first high after a conv_start is stored at the index of the channel then selected.
- R6: Each channel occupies SETTLE_CYC + 1 + D cycles of scan_busy. D counts the cycles from the one after conv_start up to and including the cycle in which conv_eoc is high. The scan length is the sum of these over all channels.
- R7: scan_done is high for exactly one cycle. That cycle is the first one in which scan_busy is low after the last channel has been written, and scan_done is high at no other time.
- R8: A scan_trig that arrives while a scan is running has no effect on the channel order, the scan length or the stored data.
- R9: rd_data presents the result stored at rd_addr as sampled on the previous clock edge (one cycle of latency).
- R10: A rd_addr of NUM_CH or above returns 0.
- R11: If rd_addr selects a channel at the same edge that channel's new result is written, rd_data shows the previous content. The new value appears on the following cycle.
- R12: conv_eoc that is high while the block is idle or settling is ignored, and no stored result changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_trig | input | 1 | Scan request, sampled each cycle |
| mux_sel | output | 6 | Analog multiplexer channel select |
| conv_start | output | 1 | One-cycle converter start |
| conv_eoc | input | 1 | Converter end-of-conversion strobe |
| conv_data | input | 12 | Converter result, valid with conv_eoc |
| scan_busy | output | 1 | High while a scan is in progress |
| scan_done | output | 1 | One-cycle scan complete pulse |
| rd_addr | input | 6 | Host read channel number |
| rd_data | output | 12 | Host read data, one cycle after rd_addr |

## Verification
The write of a fresh result and a host read can land on the same channel in the same cycle. This is the collision case the bench provokes. During a scan with random data, the bench parks rd_addr on a randomly chosen channel. It then waits for the end-of-conversion strobe for that channel. Right after the write edge, rd_data must still show the value from the previous scan. One cycle later it must show the new value. This pins the store's ordering as read-before-write. Stray triggers and stray strobes in the same runs confirm that neither disturbs the scan length nor the stored data.

// File: rtl/scan_pkg.sv
// Shared types for the channel scan sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package scan_pkg;

    // Sequencer phase for the channel currently selected.
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SETTLE = 2'd1,
        SQ_START  = 2'd2,
        SQ_WAIT   = 2'd3
    } sq_state_t;

endpackage

// File: rtl/settle_timer.sv
// Settle timer: counts the cycles a channel has been held on the
// multiplexer and flags the last cycle of the settling interval.
// Assumes: run is high for one unbroken stretch per channel and drops
// for at least one cycle between channels; SETTLE_CYC >= 1.
module settle_timer #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Count held cycles while running, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST_CNT) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expiry on the final settling cycle.
    always_comb begin
        expired = run && (cnt == LAST_CNT);
    end

    // R4: the count never passes the settle length while running.
    a_r4_settle_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= LAST_CNT));

    // R4: a fresh settling interval always starts its count at zero.
    a_r4_settle_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run)) |-> (cnt == '0));

endmodule

// File: rtl/scan_fsm.sv
// Scan sequencer: walks channels 0..NUM_CH-1, settling, starting the
// converter and waiting for its strobe on each, and emits a write
// request per result plus a one-cycle done pulse at the end.
// Assumes: the converter raises conv_eoc once per conv_start, at least
// one cycle after it; strobes at other times are ignored.
module scan_fsm
    import scan_pkg::*;
#(
    parameter int NUM_CH = 48,
    parameter int DATA_W = 12,
    parameter int CH_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_trig,
    input  logic              settle_done,
    input  logic              conv_eoc,
    input  logic [DATA_W-1:0] conv_data,
    output sq_state_t         state,
    output logic [CH_W-1:0]   chan,
    output logic              conv_start,
    output logic              scan_busy,
    output logic              scan_done,
    output logic              wr_en,
    output logic [CH_W-1:0]   wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    // Phase, channel and done-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            chan      <= '0;
            scan_done <= 1'b0;
        end else begin
            scan_done <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (scan_trig) begin
                        state <= SQ_SETTLE;
                        chan  <= '0;
                    end
                end
                SQ_SETTLE: begin
                    if (settle_done) begin
                        state <= SQ_START;
                    end
                end
                SQ_START: begin
                    state <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (conv_eoc) begin
                        if (chan == LAST_CH) begin
                            state     <= SQ_IDLE;
                            scan_done <= 1'b1;
                        end else begin
                            chan  <= chan + 1'b1;
                            state <= SQ_SETTLE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Outputs decoded from the phase register.
    always_comb begin
        conv_start = (state == SQ_START);
        scan_busy  = (state != SQ_IDLE);
        wr_en      = (state == SQ_WAIT) && conv_eoc;
        wr_addr    = chan;
        wr_data    = conv_data;
    end

    // R3: the channel moves only when a settling interval begins.
    a_r3_sel_at_settle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan) |-> (state == SQ_SETTLE && $past(state) != SQ_SETTLE));

    // R3: stepping from one channel to the next is always by one.
    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_SETTLE && $past(state) == SQ_WAIT) |-> (chan == $past(chan) + 1'b1));

    // R4: the converter start never lasts two cycles.
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R7: done is a single cycle and only appears once idle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (!scan_busy && $past(chan) == LAST_CH));

    // R8: channel 0 is only entered from idle, never mid-scan.
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_SETTLE && $past(state) != SQ_SETTLE && chan == '0)
            |-> ($past(state) == SQ_IDLE));

endmodule

// File: rtl/result_store.sv
// Result store: one DATA_W entry per channel, written by the sequencer
// and read by the host through a registered port (read-before-write).
// Assumes: rd_addr may exceed the channel count; such reads return 0.
module result_store #(
    parameter int NUM_CH = 48,
    parameter int DATA_W = 12,
    parameter int CH_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    logic [DATA_W-1:0] mem [NUM_CH];

    // Entry storage, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en && wr_addr <= LAST_CH) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered host read with range guard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_addr <= LAST_CH) begin
            rd_data <= mem[rd_addr];
        end else begin
            rd_data <= '0;
        end
    end

    // R5: writes target a real channel.
    a_r5_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr <= LAST_CH));

    // R10: reads beyond the channel count come back as zero.
    a_r10_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_addr) > LAST_CH) |-> (rd_data == '0));

endmodule

// File: rtl/chan_scan_seq.sv
// Channel scan sequencer top: ties the sequencer, settle timer and
// result store together and exposes the multiplexer, converter and
// host read connections.
// Assumes: one external converter, one strobe per start.
module chan_scan_seq
    import scan_pkg::*;
#(
    parameter int NUM_CH     = 48,
    parameter int DATA_W     = 12,
    parameter int SETTLE_CYC = 16,
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_trig,
    output logic [CH_W-1:0]   mux_sel,
    output logic              conv_start,
    input  logic              conv_eoc,
    input  logic [DATA_W-1:0] conv_data,
    output logic              scan_busy,
    output logic              scan_done,
    input  logic [CH_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    sq_state_t         state;
    logic [CH_W-1:0]   chan;
    logic              settle_done;
    logic              settle_run;
    logic              wr_en;
    logic [CH_W-1:0]   wr_addr;
    logic [DATA_W-1:0] wr_data;

    // Timer runs only in the settling phase.
    always_comb begin
        settle_run = (state == SQ_SETTLE);
        mux_sel    = chan;
    end

    settle_timer #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (settle_run),
        .expired (settle_done)
    );

    scan_fsm #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .CH_W   (CH_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_trig   (scan_trig),
        .settle_done (settle_done),
        .conv_eoc    (conv_eoc),
        .conv_data   (conv_data),
        .state       (state),
        .chan        (chan),
        .conv_start  (conv_start),
        .scan_busy   (scan_busy),
        .scan_done   (scan_done),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );

    result_store #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .CH_W   (CH_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R12: strobes outside the wait phase never produce a write.
    a_r12_stray_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_eoc && state != SQ_WAIT) |-> !wr_en);

endmodule

// File: tb/sim_chan_scan_seq.sv
// Bench for chan_scan_seq: fixed-latency converter model, random data
// per scan, directed collision, stray trigger and stray strobe cases.
module sim_chan_scan_seq;
    localparam int NUM_CH = 48;
    localparam int DATA_W = 12;
    localparam int SETTLE = 16;
    localparam int LAT    = 24;
    localparam int EXP_SCAN = NUM_CH * (SETTLE + 2 + LAT);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scan_trig = 1'b0;
    logic [5:0]        mux_sel;
    logic              conv_start;
    logic              conv_eoc;
    logic [DATA_W-1:0] conv_data;
    logic              scan_busy;
    logic              scan_done;
    logic [5:0]        rd_addr = '0;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] cur_vals  [NUM_CH];
    logic [DATA_W-1:0] prev_vals [NUM_CH];
    logic [DATA_W-1:0] hold;
    logic [DATA_W-1:0] junk = '0;
    logic              model_eoc;
    logic              stray_eoc = 1'b0;
    int                cnt;

    always #4 clk = ~clk;

    chan_scan_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_trig  (scan_trig),
        .mux_sel    (mux_sel),
        .conv_start (conv_start),
        .conv_eoc   (conv_eoc),
        .conv_data  (conv_data),
        .scan_busy  (scan_busy),
        .scan_done  (scan_done),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    assign conv_eoc  = model_eoc | stray_eoc;
    assign conv_data = stray_eoc ? junk : hold;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Fixed-latency converter: strobe LAT+1 cycles after the start cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= 0;
            model_eoc <= 1'b0;
            hold      <= '0;
        end else begin
            model_eoc <= 1'b0;
            if (conv_start) begin
                cnt  <= LAT;
                hold <= cur_vals[mux_sel];
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) model_eoc <= 1'b1;
            end
        end
    end

    // Scan monitor: order, settle length, scan length, done pulse.
    int   busy_cnt = 0;
    int   starts = 0;
    int   age = 0;
    logic p_busy = 1'b0;
    logic [5:0] p_sel = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (scan_busy && !p_busy) begin
                busy_cnt = 1; starts = 0; age = 1;
                chk(mux_sel == 0, "R2 first channel", mux_sel, 0);
            end else if (scan_busy) begin
                busy_cnt++;
                if (mux_sel != p_sel) begin
                    chk(mux_sel == p_sel + 6'd1, "R3 ascending", mux_sel, p_sel + 1);
                    age = 1;
                end else begin
                    age++;
                end
            end else if (mux_sel != p_sel) begin
                chk(1'b0, "R3 select moved while idle", mux_sel, p_sel);
            end
            if (conv_start) begin
                starts++;
                chk(age == SETTLE + 1, "R4 settle length", age, SETTLE + 1);
            end
            if (!scan_busy && p_busy) begin
                chk(busy_cnt == EXP_SCAN, "R6 scan length", busy_cnt, EXP_SCAN);
                chk(scan_done == 1'b1, "R7 done at end", scan_done, 1);
                chk(starts == NUM_CH, "R3 one start per channel", starts, NUM_CH);
            end else if (scan_done) begin
                chk(1'b0, "R7 done out of place", 1, 0);
            end
            p_busy = scan_busy;
            p_sel  = mux_sel;
        end
    end

    task automatic rd(input int a, output logic [DATA_W-1:0] d);
        @(negedge clk) rd_addr = 6'(a);
        @(negedge clk) d = rd_data;
    endtask

    task automatic check_all(input string req);
        logic [DATA_W-1:0] d;
        for (int i = 0; i < NUM_CH; i++) begin
            rd(i, d);
            chk(d == cur_vals[i], req, d, cur_vals[i]);
        end
    endtask

    task automatic new_vals();
        for (int i = 0; i < NUM_CH; i++) begin
            prev_vals[i] = cur_vals[i];
            cur_vals[i]  = DATA_W'($urandom);
        end
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!scan_done);
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        int c;
        int cyc;
        int phase;
        logic [5:0] last;
        void'($urandom(32'd4242));
        for (int i = 0; i < NUM_CH; i++) begin
            cur_vals[i] = '0;
            prev_vals[i] = '0;
        end

        // R1: reset state.
        repeat (4) @(negedge clk);
        chk(!scan_busy && !scan_done && !conv_start && mux_sel == 0,
            "R1 outputs in reset", {scan_busy, scan_done, conv_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!scan_busy && !scan_done && !conv_start && mux_sel == 0,
            "R1 outputs after reset", {scan_busy, scan_done, conv_start}, 0);
        check_all("R1 results zero");

        // Scan 1: random data, single trigger pulse.
        new_vals();
        @(negedge clk) scan_trig = 1'b1;
        @(negedge clk) scan_trig = 1'b0;
        chk(scan_busy == 1'b1, "R2 busy after trigger", scan_busy, 1);
        wait_done();
        check_all("R5 R9 results scan 1");

        // Scan 2: stray triggers mid-scan, parked read on one channel (R8, R11).
        new_vals();
        c = 10 + ($urandom % 30);
        phase = 0;
        cyc = 0;
        @(negedge clk) rd_addr = 6'(c);
        scan_trig = 1'b1;
        do begin
            @(negedge clk);
            cyc++;
            scan_trig = (cyc == 200 || cyc == 901 || cyc == 1500);
            if (phase == 1) begin
                chk(rd_data == prev_vals[c], "R11 old value at write edge", rd_data, prev_vals[c]);
                phase = 2;
            end else if (phase == 2) begin
                chk(rd_data == cur_vals[c], "R11 new value next cycle", rd_data, cur_vals[c]);
                phase = 3;
            end
            if (phase == 0 && conv_eoc && mux_sel == 6'(c)) phase = 1;
        end while (!scan_done);
        scan_trig = 1'b0;
        chk(phase == 3, "R11 collision reached", phase, 3);
        @(negedge clk);
        check_all("R8 R5 results scan 2");

        // R12: strobes while idle leave the store unchanged.
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) junk = DATA_W'($urandom); stray_eoc = 1'b1;
            @(negedge clk) stray_eoc = 1'b0;
        end
        chk(!scan_busy, "R12 idle strobe starts nothing", scan_busy, 0);
        check_all("R12 results after idle strobes");

        // R10: addresses past the last channel read zero.
        for (int a = NUM_CH; a < 64; a += 5) begin
            rd(a, d);
            chk(d == 0, "R10 out of range read", d, 0);
        end

        // Scan 3: trigger held 3 cycles, strobes injected while settling.
        new_vals();
        @(negedge clk) scan_trig = 1'b1;
        repeat (3) @(negedge clk);
        scan_trig = 1'b0;
        last = mux_sel;
        for (int k = 0; k < 5; k++) begin
            do @(negedge clk); while (mux_sel == last);
            last = mux_sel;
            repeat (3) @(negedge clk);
            junk = DATA_W'($urandom);
            stray_eoc = 1'b1;
            @(negedge clk) stray_eoc = 1'b0;
        end
        wait_done();
        check_all("R12 R8 results scan 3");

        // R9: latency of one cycle after an address change.
        rd(5, d);
        chk(d == cur_vals[5], "R9 read latency", d, cur_vals[5]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule